// File: doc/BRIEF.md
# Sticky Overflow Status and Interrupt Mask

This block gathers overflow events from four channels and keeps them in a status register that holds each event until software reads it. Each status bit is active-low. A bit reads 1 while its channel is clean. It reads 0 from the clock edge after an overflow event until the status register is read. A read returns the value the register held before the read and clears it in the same cycle. An event that arrives during that read stays recorded.

A second register holds one enable bit per channel. The block combines the status and enable bits into a single interrupt request, `irq_pull_low`. The pad driver outside the block uses this request to pull a shared active-low open-drain line to ground. A channel whose enable bit is 0 still records its overflows but cannot pull the line low. Setting the enable bit again while an overflow is pending raises the request at once.

Each channel's sticky bit is a two-state machine, `CH_CLEAN` or `CH_HELD`:
- `EV_CAPTURE` moves `CH_CLEAN` to `CH_HELD` on an event.
- `EV_RELEASE` moves `CH_HELD` to `CH_CLEAN` on a status read with no event in the same cycle.
- `EV_HOLD` keeps `CH_HELD` when an event and a read come together.

Every other case stays in the current state. The bus decoder sorts each cycle into one of these access kinds: `ACC_IDLE`, `ACC_STAT_RD`, `ACC_STAT_WR`, `ACC_MASK_RD`, `ACC_MASK_WR` or `ACC_OTHER`.

Top module: `ovf_sticky_irq`

## Requirements
- R1: After reset, the status register (address 0x02) reads 0xFF, the mask register (address 0x03) reads 0xFF and `irq_pull_low` is 0.
- R2: A 1 on `ovf_evt[i]` at a clock edge makes status bit i read 0 after that edge. The bit stays 0 over any number of cycles in which the status register is not read.
- R3: While `bus_rd` is 1 with address 0x02, `bus_rdata` shows the status as it was before the read. After that clock edge, all status bits whose channel had no event in that cycle read 1.
- R4: If an event on channel i falls in the same cycle as a status read, status bit i reads 0 after the read.
- R5: A write to address 0x03 loads `bus_wdata[3:0]` into mask bits 3:0. Bits 7:4 of both registers always read 1, and written values for those bits are ignored.
- R6: `irq_pull_low` is 1 exactly when at least one channel has status bit 0 and mask bit 1. A channel with mask bit 0 never causes a 1.
- R7: A channel with mask bit 0 still records overflows in its status bit. Writing its mask bit to 1 while the bit is pending makes `irq_pull_low` 1 in the cycle after the write edge.
- R8: Writes to address 0x02 leave the status register unchanged.
- R9: Unmapped addresses read 0xFF, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_evt | input | 4 | Per-channel overflow event, one cycle per event |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe; a status read clears at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq_pull_low | output | 1 | 1 requests that the shared open-drain line be pulled low |

## Verification
A wrong channel state appears on `bus_rdata` at the next status read. It also appears on `irq_pull_low` in the cycle right after the faulty edge, provided that channel is enabled. A lost event shows as a status bit of 1 where 0 is expected, and a read that fails to clear shows as a second read returning the same 0. A clear that comes too early erases the pre-read value in the data returned. Faults in the mask register are hidden until a channel is pending. For that reason the bench combines every mask change with pending overflows and checks the interrupt before and after the change.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic {
        CH_CLEAN = 1'b0,
        CH_HELD  = 1'b1
    } ch_state_e;

    typedef enum logic [2:0] {
        ACC_IDLE    = 3'd0,
        ACC_STAT_RD = 3'd1,
        ACC_STAT_WR = 3'd2,
        ACC_MASK_RD = 3'd3,
        ACC_MASK_WR = 3'd4,
        ACC_OTHER   = 3'd5
    } acc_kind_e;

endpackage

// File: rtl/ovf_chan_fsm.sv
module ovf_chan_fsm
    import ovf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr_rd,
    output logic stat_n
);

    ch_state_e state_q;
    ch_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: EV_CAPTURE, EV_RELEASE, EV_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_CLEAN: begin
                if (evt) begin
                    state_d = CH_HELD;
                end
            end
            CH_HELD: begin
                if (clr_rd && !evt) begin
                    state_d = CH_CLEAN;
                end
            end
            default: state_d = CH_CLEAN;
        endcase
    end

    // outputs: active-low status
    always_comb begin
        unique case (state_q)
            CH_CLEAN: stat_n = 1'b1;
            CH_HELD:  stat_n = 1'b0;
            default:  stat_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/ovf_bus_dec.sv
module ovf_bus_dec
    import ovf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 2,
    parameter int MASK_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NUM_CH-1:0] stat_vec,
    output logic [NUM_CH-1:0] mask_vec,
    output logic              clr_rd,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    acc_kind_e         acc;
    logic [NUM_CH-1:0] mask_q;

    // classify this cycle's access
    always_comb begin
        acc = ACC_IDLE;
        if (bus_rd || bus_wr) begin
            if (bus_addr == A_STAT) begin
                acc = bus_rd ? ACC_STAT_RD : ACC_STAT_WR;
            end else if (bus_addr == A_MASK) begin
                acc = bus_wr ? ACC_MASK_WR : ACC_MASK_RD;
            end else begin
                acc = ACC_OTHER;
            end
        end
    end

    // mask register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (acc == ACC_MASK_WR) begin
            mask_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    assign mask_vec = mask_q;

    // a status read clears the sticky bits at this edge
    assign clr_rd = (acc == ACC_STAT_RD);

    // read data shows the addressed register before any clear takes effect
    always_comb begin
        bus_rdata = '1;
        if (bus_addr == A_STAT) begin
            bus_rdata[NUM_CH-1:0] = stat_vec;
        end else if (bus_addr == A_MASK) begin
            bus_rdata[NUM_CH-1:0] = mask_q;
        end
    end

endmodule

// File: rtl/ovf_irq_comb.sv
module ovf_irq_comb #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] stat_vec,
    input  logic [NUM_CH-1:0] mask_vec,
    output logic              irq_pull_low
);

    logic [NUM_CH-1:0] pend;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pend
        assign pend[g] = !stat_vec[g] && mask_vec[g];
    end

    assign irq_pull_low = |pend;

endmodule

// File: rtl/ovf_sticky_irq.sv
module ovf_sticky_irq
    import ovf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 2,
    parameter int MASK_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ovf_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pull_low
);

    logic [NUM_CH-1:0] stat_vec;
    logic [NUM_CH-1:0] mask_vec;
    logic              clr_rd;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ovf_chan_fsm u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (ovf_evt[g]),
            .clr_rd (clr_rd),
            .stat_n (stat_vec[g])
        );
    end

    ovf_bus_dec #(
        .NUM_CH    (NUM_CH),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .stat_vec  (stat_vec),
        .mask_vec  (mask_vec),
        .clr_rd    (clr_rd),
        .bus_rdata (bus_rdata)
    );

    ovf_irq_comb #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .stat_vec     (stat_vec),
        .mask_vec     (mask_vec),
        .irq_pull_low (irq_pull_low)
    );

endmodule

// File: rtl/ovf_sticky_irq_chk.sv
module ovf_sticky_irq_chk #(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 2,
    parameter int MASK_ADDR = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ovf_evt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_pull_low,
    input logic [NUM_CH-1:0] stat_vec,
    input logic [NUM_CH-1:0] mask_vec
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    logic stat_rd;
    assign stat_rd = bus_rd && (bus_addr == A_STAT);

    // R2: a held bit cannot return to 1 without a status read
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((~$past(stat_vec) & stat_vec) == '0));

    // R2 and R4: every event is recorded, even during a read
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt != '0) |=> ((stat_vec & $past(ovf_evt)) == '0));

    // R3: a read with no events leaves every bit clean
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ovf_evt == '0) |=> (&stat_vec));

    // R5: reserved bits of the mapped registers read 1
    p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT || bus_addr == A_MASK) |-> (&bus_rdata[DATA_W-1:NUM_CH]));

    // R6: with all channels disabled the line is never pulled
    p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec == '0) |-> !irq_pull_low);

    // R8: writes to the status address change nothing
    p_status_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == A_STAT && ovf_evt == '0) |=> $stable(stat_vec));

endmodule

bind ovf_sticky_irq ovf_sticky_irq_chk #(
    .NUM_CH    (NUM_CH),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .MASK_ADDR (MASK_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovf_evt      (ovf_evt),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .irq_pull_low (irq_pull_low),
    .stat_vec     (stat_vec),
    .mask_vec     (mask_vec)
);

// File: tb/test_ovf_sticky_irq.sv
module test_ovf_sticky_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ovf_evt = '0;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_pull_low;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ovf_sticky_irq i_ovf_sticky_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovf_evt      (ovf_evt),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_pull_low (irq_pull_low)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse_evt(input logic [3:0] m);
        @(negedge clk);
        ovf_evt = m;
        @(negedge clk);
        ovf_evt = '0;
    endtask

    // drive a read for one cycle; returns data seen before the edge
    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = v;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 irq", {7'd0, irq_pull_low}, 8'h00);
        rd_reg(8'h03, d);
        check("R1 mask", d, 8'hFF);
        rd_reg(8'h02, d);
        check("R1 status", d, 8'hFF);
    endtask

    task automatic t_sticky;
        logic [7:0] d;
        pulse_evt(4'b0101);
        check("R6 irq on event", {7'd0, irq_pull_low}, 8'h01);
        repeat (3) @(negedge clk);
        check("R2 irq still set", {7'd0, irq_pull_low}, 8'h01);
        rd_reg(8'h02, d);
        check("R2 R3 status pre-clear", d, 8'hFA);
        check("R3 irq after clear", {7'd0, irq_pull_low}, 8'h00);
        rd_reg(8'h02, d);
        check("R3 status cleared", d, 8'hFF);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        pulse_evt(4'b0010);
        @(negedge clk);
        bus_addr = 8'h02;
        bus_rd = 1'b1;
        ovf_evt = 4'b1010;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        ovf_evt = '0;
        check("R3 pre-clear data", d, 8'hFD);
        check("R4 irq kept", {7'd0, irq_pull_low}, 8'h01);
        rd_reg(8'h02, d);
        check("R4 event kept", d, 8'hF5);
        rd_reg(8'h02, d);
        check("R4 then clear", d, 8'hFF);
    endtask

    task automatic t_mask_rw;
        logic [7:0] d;
        wr_reg(8'h03, 8'h0A);
        rd_reg(8'h03, d);
        check("R5 mask low bits", d, 8'hFA);
        wr_reg(8'h03, 8'h35);
        rd_reg(8'h03, d);
        check("R5 upper ignored", d, 8'hF5);
    endtask

    task automatic t_gating;
        logic [7:0] d;
        wr_reg(8'h03, 8'h0E);
        pulse_evt(4'b0001);
        check("R6 masked ch0", {7'd0, irq_pull_low}, 8'h00);
        pulse_evt(4'b1000);
        check("R6 unmasked ch3", {7'd0, irq_pull_low}, 8'h01);
        rd_reg(8'h02, d);
        check("R6 status both", d, 8'hF6);
        check("R6 irq cleared", {7'd0, irq_pull_low}, 8'h00);
    endtask

    task automatic t_unmask;
        logic [7:0] d;
        wr_reg(8'h03, 8'h00);
        pulse_evt(4'b0100);
        check("R7 masked no irq", {7'd0, irq_pull_low}, 8'h00);
        repeat (2) @(negedge clk);
        check("R7 still no irq", {7'd0, irq_pull_low}, 8'h00);
        wr_reg(8'h03, 8'h04);
        check("R7 unmask asserts", {7'd0, irq_pull_low}, 8'h01);
        rd_reg(8'h02, d);
        check("R7 recorded while masked", d, 8'hFB);
        wr_reg(8'h03, 8'h0F);
    endtask

    task automatic t_readonly;
        logic [7:0] d;
        pulse_evt(4'b0001);
        wr_reg(8'h02, 8'hFF);
        rd_reg(8'h02, d);
        check("R8 write ignored held", d, 8'hFE);
        wr_reg(8'h02, 8'h00);
        rd_reg(8'h02, d);
        check("R8 write ignored clean", d, 8'hFF);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        pulse_evt(4'b0010);
        wr_reg(8'h05, 8'h00);
        rd_reg(8'h05, d);
        check("R9 unmapped read", d, 8'hFF);
        rd_reg(8'h03, d);
        check("R9 mask untouched", d, 8'hFF);
        rd_reg(8'h02, d);
        check("R9 status untouched", d, 8'hFD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_collide();
        t_mask_rw();
        wr_reg(8'h03, 8'h0F);
        t_gating();
        wr_reg(8'h03, 8'h0F);
        t_unmask();
        t_readonly();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule